// File: doc/BRIEF.md
# Commit-Gated Speculative Data Cache

This block is a direct-mapped, read-only data cache for an out-of-order core. It keeps loads that have not yet retired from leaving a timing footprint that other instructions can see. Each line records whether the instruction that filled it has retired, and which instruction that was. Only a retired fill, or the filling instruction itself, gets the fast one-cycle response. Any other instruction that touches a line whose filler is still in flight is served with exactly the timing of a miss.

A mode pin picks how such a guarded access is served. In refetch mode the line is read again from backing memory, and ownership passes to the new requester. In stall mode the cache waits for as long as a memory access would take and then returns the data it already holds. The core reports retirement on a commit port and cancellation on a squash port. Both ports carry the instruction tag. The cache handles one request at a time, and backing memory answers after a fixed number of cycles.

Top module: `spec_commit_cache`

## Requirements
- R1: After reset `req_ready` is 1, while `resp_valid` and `mem_rd_en` are 0. Every line is invalid, so the first access to any address reads backing memory.
- R2: An access to an invalid line, or to a line holding another address, raises `mem_rd_en` with `mem_addr` equal to the request address in its acceptance cycle. It returns the memory word with `resp_valid` exactly MEM_LAT+1 cycles after acceptance. The line is then installed, uncommitted and owned by the requesting tag.
- R3: `req_ready` is 0 from the cycle after a slow (MEM_LAT+1) access is accepted until its response cycle. It is 1 in every cycle in which `resp_valid` is 1.
- R4: A commit whose tag equals the owner of an uncommitted line marks that line committed. Afterwards any tag hits it with the response one cycle after acceptance and no memory read.
- R5: With `hide_stall`=0, an access by a tag other than the owner to a valid, uncommitted line reads backing memory. It answers after MEM_LAT+1 cycles with the fresh memory word, and the requester becomes the owner while the line stays uncommitted.
- R6: With `hide_stall`=1, the same guarded access issues no memory read. It answers after MEM_LAT+1 cycles with the data already in the line.
- R7: A repeat access by the owning tag to its own uncommitted line responds one cycle after acceptance with the cached data and no memory read.
- R8: A squash whose tag owns an uncommitted line invalidates that line, so the next access reads memory. A squash of the tag that filled a line already committed has no effect.
- R9: A commit or squash whose tag matches no uncommitted owner leaves every line unchanged.
- R10: If the tag of an in-flight fill is squashed before its response, the response still arrives MEM_LAT+1 cycles after acceptance, but the line is not installed.
- R11: The line index is the low log2(LINES) address bits and the rest of the address is the line tag. An access whose index matches but whose tag differs is a miss, and it replaces the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hide_stall | input | 1 | 1: guarded access stalls and returns cached data; 0: guarded access refetches |
| req_valid | input | 1 | Load request strobe |
| req_addr | input | ADDR_W | Word address of the load |
| req_itag | input | ITAG_W | Instruction tag of the load |
| req_ready | output | 1 | Cache can accept a request this cycle |
| resp_valid | output | 1 | Response strobe |
| resp_data | output | DATA_W | Load data |
| commit_valid | input | 1 | Retirement strobe |
| commit_itag | input | ITAG_W | Tag of the retiring instruction |
| squash_valid | input | 1 | Cancellation strobe |
| squash_itag | input | ITAG_W | Tag of the cancelled instruction |
| mem_rd_en | output | 1 | Backing-memory read request |
| mem_addr | output | ADDR_W | Backing-memory read address |
| mem_rvalid | input | 1 | Backing-memory data valid, MEM_LAT cycles after the request |
| mem_rdata | input | DATA_W | Backing-memory read data |

## Verification
The hardest case to reach from the ports is a squash that lands while a fill is still in flight. It has to arrive after acceptance and before the response, and its only visible trace is that the next access misses. The stimulus forks a request and a delayed squash of the same tag, then probes the line.

A guarded access in refetch mode looks the same as a miss at the ports. The bench therefore changes the backing-memory contents between accesses and uses stall mode as a probe: a stall returns the old word without a memory read. This shows whether a line is still present, still uncommitted, or owned by a new tag.

// File: rtl/scc_pkg.sv
// Shared types for the commit-gated cache.
// Assumes nothing beyond a SystemVerilog-2017 compiler.
package scc_pkg;

    // Classification of a request against the addressed line
    typedef enum logic [1:0] {
        LK_MISS  = 2'd0,   // invalid line or different address
        LK_HIT   = 2'd1,   // committed, or owned by the requester
        LK_GUARD = 2'd2    // present but owned by another in-flight tag
    } lookup_kind_e;

    // Controller states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/scc_line_array.sv
// Line storage: per line a valid bit, committed bit, address tag, owner tag
// and data word. Applies commit and squash broadcasts to every line in
// parallel, and takes one install per cycle from the controller.
// Assumes an install overrides a commit or squash aimed at the same line.
module scc_line_array #(
    parameter int LINES   = 16,
    parameter int INDEX_W = 4,
    parameter int LTAG_W  = 6,
    parameter int ITAG_W  = 6,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INDEX_W-1:0] rd_idx,
    output logic              rd_valid,
    output logic              rd_committed,
    output logic [LTAG_W-1:0] rd_ltag,
    output logic [ITAG_W-1:0] rd_owner,
    output logic [DATA_W-1:0] rd_data,
    input  logic              commit_valid,
    input  logic [ITAG_W-1:0] commit_itag,
    input  logic              squash_valid,
    input  logic [ITAG_W-1:0] squash_itag,
    input  logic              inst_en,
    input  logic [INDEX_W-1:0] inst_idx,
    input  logic [LTAG_W-1:0] inst_ltag,
    input  logic [ITAG_W-1:0] inst_owner,
    input  logic [DATA_W-1:0] inst_data
);

    logic [LINES-1:0]  valid_vec;
    logic [LINES-1:0]  commit_vec;
    logic [LTAG_W-1:0] ltag_arr  [LINES];
    logic [ITAG_W-1:0] owner_arr [LINES];
    logic [DATA_W-1:0] data_arr  [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic              v_q;
        logic              c_q;
        logic [LTAG_W-1:0] t_q;
        logic [ITAG_W-1:0] o_q;
        logic [DATA_W-1:0] d_q;
        logic              inst_here;
        logic              commit_hit;
        logic              squash_hit;

        assign inst_here  = inst_en && (inst_idx == INDEX_W'(i));
        assign commit_hit = commit_valid && v_q && !c_q && (o_q == commit_itag);
        assign squash_hit = squash_valid && v_q && !c_q && (o_q == squash_itag);

        // Flag update: install, then commit, then squash (squash wins)
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                c_q <= 1'b0;
            end else if (inst_here) begin
                v_q <= 1'b1;
                c_q <= 1'b0;
            end else begin
                if (commit_hit) c_q <= 1'b1;
                if (squash_hit) v_q <= 1'b0;
            end
        end

        // Payload update on install only
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                t_q <= '0;
                o_q <= '0;
                d_q <= '0;
            end else if (inst_here) begin
                t_q <= inst_ltag;
                o_q <= inst_owner;
                d_q <= inst_data;
            end
        end

        assign valid_vec[i]  = v_q;
        assign commit_vec[i] = c_q;
        assign ltag_arr[i]   = t_q;
        assign owner_arr[i]  = o_q;
        assign data_arr[i]   = d_q;

        // R4
        commit_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (commit_hit && !inst_here && !squash_hit) |=> c_q);

        // R8
        squash_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (squash_hit && !inst_here) |=> !v_q);

        // R9
        committed_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (v_q && c_q && !inst_here) |=> (v_q && c_q));
    end

    // Read port: the line selected by the current request index
    always_comb begin
        rd_valid     = valid_vec[rd_idx];
        rd_committed = commit_vec[rd_idx];
        rd_ltag      = ltag_arr[rd_idx];
        rd_owner     = owner_arr[rd_idx];
        rd_data      = data_arr[rd_idx];
    end

endmodule

// File: rtl/scc_lookup.sv
// Combinational lookup: splits the request address into line index and
// line tag, and classifies the addressed line as miss, hit or guarded.
// Assumes the line fields arrive from the array for rd_idx in the same cycle.
module scc_lookup
    import scc_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int ITAG_W  = 6,
    parameter int INDEX_W = 4,
    parameter int LTAG_W  = 6
) (
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [ITAG_W-1:0]  req_itag,
    input  logic               line_valid,
    input  logic               line_committed,
    input  logic [LTAG_W-1:0]  line_ltag,
    input  logic [ITAG_W-1:0]  line_owner,
    output logic [INDEX_W-1:0] rd_idx,
    output lookup_kind_e       kind
);

    logic present;

    assign rd_idx  = req_addr[INDEX_W-1:0];
    assign present = line_valid && (line_ltag == req_addr[ADDR_W-1:INDEX_W]);

    // Classification: only committed lines or the owner's own line are fast
    always_comb begin
        if (!present)
            kind = LK_MISS;
        else if (line_committed || (line_owner == req_itag))
            kind = LK_HIT;
        else
            kind = LK_GUARD;
    end

endmodule

// File: rtl/scc_ctrl.sv
// Request controller: accepts one load at a time, answers hits in one
// cycle and everything else after exactly MEM_LAT+1 cycles, by refetch
// or by a counted stall. Tracks squash of the in-flight fill.
// Assumes memory answers exactly MEM_LAT cycles after mem_rd_en, and that
// the core never commits a load before its response.
module scc_ctrl
    import scc_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int ITAG_W  = 6,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 4,
    parameter int LTAG_W  = 6,
    parameter int MEM_LAT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hide_stall,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [ITAG_W-1:0]  req_itag,
    output logic               req_ready,
    input  lookup_kind_e       kind,
    input  logic [DATA_W-1:0]  line_data,
    input  logic               squash_valid,
    input  logic [ITAG_W-1:0]  squash_itag,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               resp_valid,
    output logic [DATA_W-1:0]  resp_data,
    output logic               inst_en,
    output logic [INDEX_W-1:0] inst_idx,
    output logic [LTAG_W-1:0]  inst_ltag,
    output logic [ITAG_W-1:0]  inst_owner,
    output logic [DATA_W-1:0]  inst_data
);

    localparam int CNT_W = $clog2(MEM_LAT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MEM_LAT - 1);

    ctrl_state_e       state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              fill_q;
    logic              kill_q;
    logic [ITAG_W-1:0] pend_itag_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [DATA_W-1:0] hold_q;
    logic              resp_valid_q;
    logic [DATA_W-1:0] resp_data_q;

    logic accept;
    logic use_mem;
    logic done;
    logic pend_squashed;
    logic kill_now;

    assign req_ready     = (state_q == ST_IDLE);
    assign accept        = req_valid && req_ready;
    assign use_mem       = (kind == LK_MISS) || ((kind == LK_GUARD) && !hide_stall);
    assign mem_rd_en     = accept && use_mem;
    assign mem_addr      = req_addr;
    assign done          = (state_q == ST_WAIT) && (cnt_q == LAST);
    assign pend_squashed = squash_valid && (squash_itag == pend_itag_q);
    assign kill_now      = kill_q || pend_squashed;

    assign inst_en    = done && fill_q && !kill_now;
    assign inst_idx   = pend_addr_q[INDEX_W-1:0];
    assign inst_ltag  = pend_addr_q[ADDR_W-1:INDEX_W];
    assign inst_owner = pend_itag_q;
    assign inst_data  = mem_rdata;

    assign resp_valid = resp_valid_q;
    assign resp_data  = resp_data_q;

    // Sequencer: accept, count the slow window, and produce the response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cnt_q        <= '0;
            fill_q       <= 1'b0;
            kill_q       <= 1'b0;
            pend_itag_q  <= '0;
            pend_addr_q  <= '0;
            hold_q       <= '0;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (kind == LK_HIT) begin
                            resp_valid_q <= 1'b1;
                            resp_data_q  <= line_data;
                        end else begin
                            state_q     <= ST_WAIT;
                            cnt_q       <= '0;
                            fill_q      <= use_mem;
                            kill_q      <= 1'b0;
                            pend_itag_q <= req_itag;
                            pend_addr_q <= req_addr;
                            hold_q      <= line_data;
                        end
                    end
                end
                ST_WAIT: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (pend_squashed) kill_q <= 1'b1;
                    if (done) begin
                        state_q      <= ST_IDLE;
                        resp_valid_q <= 1'b1;
                        resp_data_q  <= fill_q ? mem_rdata : hold_q;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2
    mem_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && fill_q) |-> (mem_rvalid == (cnt_q == LAST)));

    // R6
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !fill_q) |-> !mem_rvalid);

    // R3
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind != LK_HIT) |=> !req_ready);

    // R7
    fast_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == LK_HIT) |=> resp_valid);

    // R5
    guard_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == LK_GUARD) |=> !resp_valid);

endmodule

// File: rtl/spec_commit_cache.sv
// Top of the commit-gated cache: line array, lookup and controller.
// Assumes one outstanding request, a fixed-latency memory and MEM_LAT >= 1.
module spec_commit_cache
    import scc_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32,
    parameter int ITAG_W  = 6,
    parameter int LINES   = 16,
    parameter int MEM_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hide_stall,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ITAG_W-1:0] req_itag,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    input  logic              commit_valid,
    input  logic [ITAG_W-1:0] commit_itag,
    input  logic              squash_valid,
    input  logic [ITAG_W-1:0] squash_itag,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int INDEX_W = $clog2(LINES);
    localparam int LTAG_W  = ADDR_W - INDEX_W;

    logic [INDEX_W-1:0] rd_idx;
    logic               line_valid;
    logic               line_committed;
    logic [LTAG_W-1:0]  line_ltag;
    logic [ITAG_W-1:0]  line_owner;
    logic [DATA_W-1:0]  line_data;
    lookup_kind_e       kind;
    logic               inst_en;
    logic [INDEX_W-1:0] inst_idx;
    logic [LTAG_W-1:0]  inst_ltag;
    logic [ITAG_W-1:0]  inst_owner;
    logic [DATA_W-1:0]  inst_data;

    scc_line_array #(
        .LINES(LINES), .INDEX_W(INDEX_W), .LTAG_W(LTAG_W),
        .ITAG_W(ITAG_W), .DATA_W(DATA_W)
    ) u_lines (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx),
        .rd_valid(line_valid), .rd_committed(line_committed),
        .rd_ltag(line_ltag), .rd_owner(line_owner), .rd_data(line_data),
        .commit_valid(commit_valid), .commit_itag(commit_itag),
        .squash_valid(squash_valid), .squash_itag(squash_itag),
        .inst_en(inst_en), .inst_idx(inst_idx), .inst_ltag(inst_ltag),
        .inst_owner(inst_owner), .inst_data(inst_data)
    );

    scc_lookup #(
        .ADDR_W(ADDR_W), .ITAG_W(ITAG_W), .INDEX_W(INDEX_W), .LTAG_W(LTAG_W)
    ) u_lookup (
        .req_addr(req_addr), .req_itag(req_itag),
        .line_valid(line_valid), .line_committed(line_committed),
        .line_ltag(line_ltag), .line_owner(line_owner),
        .rd_idx(rd_idx), .kind(kind)
    );

    scc_ctrl #(
        .ADDR_W(ADDR_W), .ITAG_W(ITAG_W), .DATA_W(DATA_W),
        .INDEX_W(INDEX_W), .LTAG_W(LTAG_W), .MEM_LAT(MEM_LAT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .hide_stall(hide_stall),
        .req_valid(req_valid), .req_addr(req_addr), .req_itag(req_itag),
        .req_ready(req_ready), .kind(kind), .line_data(line_data),
        .squash_valid(squash_valid), .squash_itag(squash_itag),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .inst_en(inst_en), .inst_idx(inst_idx), .inst_ltag(inst_ltag),
        .inst_owner(inst_owner), .inst_data(inst_data)
    );

endmodule

// File: tb/spec_commit_cache_tb.sv
module spec_commit_cache_tb;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int ITAG_W = 6;
    localparam int LINES  = 16;
    localparam int N      = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hide_stall = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [ITAG_W-1:0] req_itag = '0;
    logic              req_ready;
    logic              resp_valid;
    logic [DATA_W-1:0] resp_data;
    logic              commit_valid = 1'b0;
    logic [ITAG_W-1:0] commit_itag = '0;
    logic              squash_valid = 1'b0;
    logic [ITAG_W-1:0] squash_itag = '0;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rvalid;
    logic [DATA_W-1:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] ver = 8'd0;

    typedef struct {
        logic [DATA_W-1:0] data;
        int                lat;
        int                acc;
        string             rq;
    } exp_t;
    exp_t sb[$];

    logic              pv [N];
    logic [DATA_W-1:0] pd [N];

    always #10 clk = ~clk;

    spec_commit_cache #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ITAG_W(ITAG_W),
        .LINES(LINES), .MEM_LAT(N)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .hide_stall(hide_stall),
        .req_valid(req_valid), .req_addr(req_addr), .req_itag(req_itag),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .commit_valid(commit_valid), .commit_itag(commit_itag),
        .squash_valid(squash_valid), .squash_itag(squash_itag),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [DATA_W-1:0] mdat(input logic [ADDR_W-1:0] a, input logic [7:0] v);
        return {v, 14'h0, a};
    endfunction

    // Fixed-latency backing memory: data visible N cycles after the request edge
    initial for (int k = 0; k < N; k++) begin pv[k] = 1'b0; pd[k] = '0; end
    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int k = N - 1; k > 0; k--) begin
            pv[k] <= pv[k-1];
            pd[k] <= pd[k-1];
        end
        pv[0] <= mem_rd_en;
        pd[0] <= mdat(mem_addr, ver);
    end
    assign mem_rvalid = pv[N-1];
    assign mem_rdata  = pd[N-1];

    task automatic chk(input logic ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard on each response and compare
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R3", "unexpected response", 64'(resp_data), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(resp_data == e.data, e.rq, "data", 64'(resp_data), 64'(e.data));
                chk((cyc - e.acc + 1) == e.lat, e.rq, "latency",
                    64'(cyc - e.acc + 1), 64'(e.lat));
                chk(req_ready == 1'b1, "R3", "ready in response cycle", 64'(req_ready), 64'd1);
            end
        end
    end

    // Driver: issue one load, check the memory request, push the expectation
    task automatic do_req(input logic [ADDR_W-1:0] a, input logic [ITAG_W-1:0] t,
                          input logic stall, input logic exp_mem,
                          input logic [DATA_W-1:0] exp_data, input int exp_lat,
                          input string rq);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_addr   = a;
        req_itag   = t;
        hide_stall = stall;
        e.data = exp_data; e.lat = exp_lat; e.acc = cyc + 1; e.rq = rq;
        sb.push_back(e);
        #1;
        chk(mem_rd_en == exp_mem, rq, "memory read", 64'(mem_rd_en), 64'(exp_mem));
        if (exp_mem) chk(mem_addr == a, rq, "memory address", 64'(mem_addr), 64'(a));
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == (exp_lat == 1), "R3", "ready after accept",
            64'(req_ready), 64'(exp_lat == 1));
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic do_commit(input logic [ITAG_W-1:0] t);
        @(negedge clk); commit_valid = 1'b1; commit_itag = t;
        @(negedge clk); commit_valid = 1'b0;
    endtask

    task automatic do_squash(input logic [ITAG_W-1:0] t);
        @(negedge clk); squash_valid = 1'b1; squash_itag = t;
        @(negedge clk); squash_valid = 1'b0;
    endtask

    localparam logic [ADDR_W-1:0] A = 10'h013;
    localparam logic [ADDR_W-1:0] B = 10'h025;
    localparam logic [ADDR_W-1:0] C = 10'h015; // same index as B (R11)
    localparam logic [ADDR_W-1:0] D = 10'h040;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready", 64'(req_ready), 64'd1);
        chk(resp_valid == 1'b0, "R1", "resp_valid", 64'(resp_valid), 64'd0);
        chk(mem_rd_en == 1'b0, "R1", "mem_rd_en", 64'(mem_rd_en), 64'd0);

        do_req(A, 6'd1, 1'b0, 1'b1, mdat(A, 8'd0), N + 1, "R2");   // first access misses (R1)
        do_req(A, 6'd1, 1'b0, 1'b0, mdat(A, 8'd0), 1, "R7");       // owner repeat
        ver = 8'd1;
        do_req(A, 6'd2, 1'b0, 1'b1, mdat(A, 8'd1), N + 1, "R5");   // refetch, owner -> 2
        ver = 8'd2;
        do_commit(6'd1);                                            // old owner: no effect (R9)
        do_req(A, 6'd3, 1'b1, 1'b0, mdat(A, 8'd1), N + 1, "R6");   // stall, cached data
        do_commit(6'd2);
        do_req(A, 6'd3, 1'b0, 1'b0, mdat(A, 8'd1), 1, "R4");       // committed: fast for all
        do_squash(6'd2);
        do_req(A, 6'd4, 1'b0, 1'b0, mdat(A, 8'd1), 1, "R8");       // squash of committed: no effect

        do_req(B, 6'd5, 1'b0, 1'b1, mdat(B, 8'd2), N + 1, "R2");
        ver = 8'd3;
        do_squash(6'd9);
        do_commit(6'd9);
        do_req(B, 6'd6, 1'b1, 1'b0, mdat(B, 8'd2), N + 1, "R9");   // still present, uncommitted
        do_squash(6'd5);
        do_req(B, 6'd6, 1'b1, 1'b1, mdat(B, 8'd3), N + 1, "R8");   // owner squash invalidated
        do_req(B, 6'd6, 1'b1, 1'b0, mdat(B, 8'd3), 1, "R7");
        do_commit(6'd6);
        do_req(C, 6'd7, 1'b0, 1'b1, mdat(C, 8'd3), N + 1, "R11");  // same index, other tag
        do_req(B, 6'd7, 1'b0, 1'b1, mdat(B, 8'd3), N + 1, "R11");  // B was evicted

        // R10: squash the in-flight fill
        fork
            do_req(D, 6'd10, 1'b0, 1'b1, mdat(D, 8'd3), N + 1, "R10");
            begin
                repeat (3) @(negedge clk);
                squash_valid = 1'b1; squash_itag = 6'd10;
                @(negedge clk);
                squash_valid = 1'b0;
            end
        join
        ver = 8'd4;
        do_req(D, 6'd11, 1'b1, 1'b1, mdat(D, 8'd4), N + 1, "R10"); // not installed

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R3", "pending responses", 64'(sb.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule